// File: doc/BRIEF.md
# Five-Channel Timer Tick Generator

This block derives one tick-enable strobe per timer channel, five channels in all, from a single peripheral clock. Two programmable prescalers divide the peripheral clock by an 8-bit value plus one. Channels 0 and 1 draw on the first prescaler. Channels 2, 3 and 4 draw on the second. Each channel then applies its own power-of-two divider to its prescaler's strobe. A channel may instead count rising edges of an external timer clock. External clock 0 serves the low channel group and external clock 1 serves the high group. Each external input is synchronised with two flops and then edge-detected.

Software programs the block through a small write port that holds two configuration words. Address 0 holds both prescaler values. Address 1 holds one 4-bit source/divider field per channel. Each write carries a nibble enable, so one channel's field can be rewritten without touching the fields of the others. The tick outputs are one-cycle enables in the peripheral clock domain, for use by the timer counters downstream. A new prescaler value or channel field does not act at once. It is picked up at a wrap of the running count, so the tick train never contains a shortened interval.

Top module: `tmr_tick_tree`

## Requirements
- R1: During reset and on the first cycles after it, all ticks are low. After reset both prescaler values and every channel field are 0, so every channel ticks every 2 cycles.
- R2: Channels 0 and 1 use prescaler 0, which is held in address-0 bits [7:0]. With value P and field code k in 0..3, the steady tick interval is (P+1)*2^(k+1) cycles.
- R3: Channels 2, 3 and 4 use prescaler 1, which is held in address-0 bits [15:8]. Their steady interval follows the same formula as R2.
- R4: The field of channel c is held in address-1 bits [4c+3:4c]. Codes 0, 1, 2 and 3 select division by 2, 4, 8 and 16.
- R5: Field code 4 selects the external clock: input 0 for channels 0 and 1, input 1 for channels 2 to 4. The channel emits exactly one tick for each rising edge of that input, provided each level is held for at least 2 cycles.
- R6: Field codes 5 to 15 stop the channel, and it emits no ticks.
- R7: Every tick is high for exactly one cycle while the channel's configuration is unchanged.
- R8: Nibble enable bit n gates write-data bits [4n+3:4n]. Bits whose nibble enable is clear keep their old value, so the other channels' tick intervals are unchanged.
- R9: A new prescaler value or field takes effect only when the running count wraps. Every tick interval that spans a change therefore lies between the old steady interval and the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | 0: prescaler word, 1: channel field word |
| cfg_wdata | input | 20 | Write data |
| cfg_nib_en | input | 5 | Per-nibble write enable |
| ext_clk | input | 2 | Asynchronous external timer clocks, one per channel group |
| tick | output | 5 | One-cycle tick enable per channel |

## Verification
Two events can fall in the same cycle: a configuration write, and a prescaler wrap or the completion of a divider count that loads the shadow copy. The bench provokes this by issuing writes at every offset from 0 to 9 cycles after a channel-0 tick. Each write swaps prescaler 0 between 2 and 7 and swaps channel 1 between codes 0 and 3. A background monitor records the shortest and longest interval between ticks on both channels. The run is judged correct if every interval stays within the bounds set by the old and new steady intervals, which exposes both runt pulses and missed wraps.

// File: rtl/tick_pkg.sv
// Shared constants and helpers for the timer tick generator.
// Assumes a fixed 4-bit channel field and four divider taps.
package tick_pkg;
    localparam int FIELD_W  = 4;
    localparam int DIV_TAPS = 4;
    localparam logic [FIELD_W-1:0] EXT_CODE = 4'd4;

    // Width of the configuration write port, rounded up to whole nibbles.
    function automatic int cfg_width(input int nch, input int ps_w);
        int raw;
        raw = (2 * ps_w > nch * FIELD_W) ? 2 * ps_w : nch * FIELD_W;
        return ((raw + 3) / 4) * 4;
    endfunction
endpackage

// File: rtl/tick_cfg_regs.sv
// Configuration storage: word 0 holds both prescaler values, word 1 holds
// one 4-bit field per channel. Writes are gated per nibble.
// Assumes DATA_W is a multiple of 4 and at least as wide as either word.
module tick_cfg_regs #(
    parameter int NCH    = 5,
    parameter int PS_W   = 8,
    parameter int DATA_W = 20
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              we,
    input  logic                              addr,
    input  logic [DATA_W-1:0]                 wdata,
    input  logic [DATA_W/4-1:0]               nib_en,
    output logic [1:0][PS_W-1:0]              ps_val,
    output logic [NCH-1:0][tick_pkg::FIELD_W-1:0] sel_val
);
    localparam int W0 = 2 * PS_W;
    localparam int W1 = NCH * tick_pkg::FIELD_W;

    logic [W0-1:0]     word0;
    logic [W1-1:0]     word1;
    logic [DATA_W-1:0] bmask;

    // Expand nibble enables to a bit mask.
    always_comb begin
        for (int b = 0; b < DATA_W; b++) bmask[b] = nib_en[b / 4];
    end

    // Masked update of the two configuration words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word0 <= '0;
            word1 <= '0;
        end else if (we) begin
            if (!addr) word0 <= (word0 & ~bmask[W0-1:0]) | (wdata[W0-1:0] & bmask[W0-1:0]);
            else       word1 <= (word1 & ~bmask[W1-1:0]) | (wdata[W1-1:0] & bmask[W1-1:0]);
        end
    end

    assign ps_val  = word0;
    assign sel_val = word1;

    // Channel 0 field holds when its nibble is not enabled.
    assert_field_isolation_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr && !nib_en[0]) |=> $stable(word1[tick_pkg::FIELD_W-1:0]));
endmodule

// File: rtl/tick_prescaler.sv
// Programmable prescaler: strobes once every (value+1) cycles. A new value
// is copied to the active register only at the wrap, so no runt interval.
module tick_prescaler #(
    parameter int PS_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PS_W-1:0] ps_cfg,
    output logic            strobe
);
    logic [PS_W-1:0] pcnt;
    logic [PS_W-1:0] ps_act;

    assign strobe = (pcnt == ps_act);

    // Count up to the active value, then wrap and reload the shadow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt   <= '0;
            ps_act <= '0;
        end else if (strobe) begin
            pcnt   <= '0;
            ps_act <= ps_cfg;
        end else begin
            pcnt <= pcnt + 1'b1;
        end
    end

    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt <= ps_act);
    assert_hold_until_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(ps_act));
endmodule

// File: rtl/tick_ext_sync.sv
// Two-flop synchroniser plus edge detector for one external timer clock.
// Assumes each input level lasts at least two clock cycles.
module tick_ext_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_in,
    output logic rise
);
    logic [2:0] sync_q;

    // Shift the asynchronous input through the sync chain and history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], ext_in};
    end

    assign rise = sync_q[1] & ~sync_q[2];

    assert_edge_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/tick_channel.sv
// One channel: picks a divide-by-2^(k+1) tap of its prescaler strobe, the
// external edge (code 4), or nothing (codes 5..15). A new field is taken at
// the divider wrap, or at a prescaler strobe when not dividing.
module tick_channel (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           pre_strobe,
    input  logic                           ext_rise,
    input  logic [tick_pkg::FIELD_W-1:0]   sel_cfg,
    output logic                           tick
);
    import tick_pkg::*;

    logic [FIELD_W-1:0]  sel_act;
    logic [DIV_TAPS-1:0] dcnt;
    logic [DIV_TAPS:0]   span;
    logic [DIV_TAPS-1:0] term;
    logic                is_div, is_ext, at_end, done;

    assign is_div = (sel_act < EXT_CODE);
    assign is_ext = (sel_act == EXT_CODE);
    assign span   = (DIV_TAPS+1)'(2) << sel_act[1:0];
    assign term   = DIV_TAPS'(span - 1'b1);
    assign at_end = (dcnt == term);
    assign done   = pre_strobe && (!is_div || at_end);

    // Divider count, shadow field load and registered tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_act <= '0;
            dcnt    <= '0;
            tick    <= 1'b0;
        end else begin
            tick <= is_div ? (pre_strobe && at_end) : (is_ext && ext_rise);
            if (done) begin
                sel_act <= sel_cfg;
                dcnt    <= '0;
            end else if (pre_strobe && is_div) begin
                dcnt <= dcnt + 1'b1;
            end
        end
    end

    assert_div_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        is_div |-> (dcnt <= term));
    assert_off_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_act > EXT_CODE) |=> !tick);
    assert_single_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && $stable(sel_act)) |=> !tick);
endmodule

// File: rtl/tmr_tick_tree.sv
// Top of the tick generator: configuration words, two prescalers, two
// external clock synchronisers and NCH channels. Channels below GRP0_N use
// prescaler 0 and external clock 0; the rest use prescaler 1 and clock 1.
module tmr_tick_tree #(
    parameter int NCH    = 5,
    parameter int PS_W   = 8,
    parameter int GRP0_N = 2,
    localparam int DATA_W = tick_pkg::cfg_width(NCH, PS_W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic                cfg_addr,
    input  logic [DATA_W-1:0]   cfg_wdata,
    input  logic [DATA_W/4-1:0] cfg_nib_en,
    input  logic [1:0]          ext_clk,
    output logic [NCH-1:0]      tick
);
    import tick_pkg::*;

    logic [1:0][PS_W-1:0]        ps_val;
    logic [NCH-1:0][FIELD_W-1:0] sel_val;
    logic [1:0]                  grp_strobe;
    logic [1:0]                  grp_rise;

    tick_cfg_regs #(.NCH(NCH), .PS_W(PS_W), .DATA_W(DATA_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .nib_en(cfg_nib_en),
        .ps_val(ps_val), .sel_val(sel_val)
    );

    for (genvar g = 0; g < 2; g++) begin : g_grp
        tick_prescaler #(.PS_W(PS_W)) u_pre (
            .clk(clk), .rst_n(rst_n), .ps_cfg(ps_val[g]), .strobe(grp_strobe[g])
        );
        tick_ext_sync u_sync (
            .clk(clk), .rst_n(rst_n), .ext_in(ext_clk[g]), .rise(grp_rise[g])
        );
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam int GRP = (c < GRP0_N) ? 0 : 1;
        tick_channel u_ch (
            .clk(clk), .rst_n(rst_n),
            .pre_strobe(grp_strobe[GRP]), .ext_rise(grp_rise[GRP]),
            .sel_cfg(sel_val[c]), .tick(tick[c])
        );
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (tick == '0));
endmodule

// File: tb/test_tmr_tick_tree.sv
module test_tmr_tick_tree;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_addr = 1'b0;
    logic [19:0] cfg_wdata = '0;
    logic [4:0]  cfg_nib_en = '0;
    logic [1:0]  ext_clk = '0;
    logic [4:0]  tick;

    int checks = 0;
    int fails  = 0;
    bit wide_seen = 0;

    // background counters and interval monitor
    bit count_en = 0;
    int tcount [5];
    bit mon_en = 0;
    int cyc = 0;
    int last_t [2] = '{-1, -1};
    int mn [2] = '{1000000, 1000000};
    int mx [2] = '{0, 0};

    always #10 clk = ~clk;   // 50 MHz

    tmr_tick_tree i_tmr_tick_tree (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_nib_en(cfg_nib_en),
        .ext_clk(ext_clk), .tick(tick)
    );

    always @(negedge clk) begin
        cyc++;
        if (count_en) for (int c = 0; c < 5; c++) tcount[c] += int'(tick[c]);
        if (mon_en) begin
            for (int c = 0; c < 2; c++) begin
                if (tick[c]) begin
                    if (last_t[c] >= 0) begin
                        if (cyc - last_t[c] < mn[c]) mn[c] = cyc - last_t[c];
                        if (cyc - last_t[c] > mx[c]) mx[c] = cyc - last_t[c];
                    end
                    last_t[c] = cyc;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic write_cfg(input bit a, input logic [19:0] d, input logic [4:0] n);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d; cfg_nib_en = n;
        @(negedge clk);
        cfg_we = 1'b0; cfg_nib_en = '0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Interval between two consecutive ticks of one channel, sampled at negedge.
    task automatic measure(input int ch, output int per);
        int t = 0;
        @(negedge clk);
        while (tick[ch] !== 1'b1 && t < 6000) begin @(negedge clk); t++; end
        @(negedge clk);
        if (tick[ch] !== 1'b0) wide_seen = 1;
        per = 1;
        while (tick[ch] !== 1'b1 && per < 6000) begin @(negedge clk); per++; end
    endtask

    task automatic t_reset();
        int p;
        wait_cyc(3);
        check(tick == 5'd0, "R1 ticks low in reset", tick, 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check(tick == 5'd0, "R1 ticks low after reset", tick, 0);
        measure(0, p);
        check(p == 2, "R1 default interval ch0", p, 2);
        measure(4, p);
        check(p == 2, "R1 default interval ch4", p, 2);
    endtask

    task automatic t_groups();
        int p;
        write_cfg(1'b0, 20'h00304, 5'h0F);   // ps0=4, ps1=3
        write_cfg(1'b1, 20'h12031, 5'h1F);   // codes ch0..4 = 1,3,0,2,1
        wait_cyc(300);
        measure(0, p); check(p == 20, "R2 ch0 ps0=4 code1", p, 20);
        measure(1, p); check(p == 80, "R2 R4 ch1 ps0=4 code3", p, 80);
        measure(2, p); check(p == 8,  "R3 R4 ch2 ps1=3 code0", p, 8);
        measure(3, p); check(p == 32, "R3 R4 ch3 ps1=3 code2", p, 32);
        measure(4, p); check(p == 16, "R3 ch4 ps1=3 code1", p, 16);
        check(!wide_seen, "R7 tick one cycle wide", int'(wide_seen), 0);
    endtask

    task automatic t_isolation();
        int p;
        write_cfg(1'b1, 20'hFFF0F, 5'h02);   // only ch1 nibble -> code 0
        write_cfg(1'b0, 20'hF09FF, 5'h0C);   // only ps1 -> 9
        wait_cyc(300);
        measure(1, p); check(p == 10, "R8 ch1 rewritten", p, 10);
        measure(0, p); check(p == 20, "R8 ch0 untouched", p, 20);
        measure(3, p); check(p == 80, "R8 ch3 field untouched", p, 80);
        measure(2, p); check(p == 20, "R8 ch2 ps1 rewritten", p, 20);
    endtask

    task automatic t_off();
        write_cfg(1'b1, 20'h70000, 5'h10);   // ch4 code 7
        wait_cyc(100);
        tcount[4] = 0; count_en = 1;
        wait_cyc(300);
        count_en = 0;
        check(tcount[4] == 0, "R6 stopped channel silent", tcount[4], 0);
    endtask

    task automatic t_ext();
        write_cfg(1'b1, 20'h04004, 5'h09);   // ch0, ch3 code 4
        wait_cyc(250);
        for (int c = 0; c < 5; c++) tcount[c] = 0;
        count_en = 1;
        for (int i = 0; i < 5; i++) begin
            ext_clk = {1'b1, (i < 3)};
            wait_cyc(4);
            ext_clk = 2'b00;
            wait_cyc(4);
        end
        wait_cyc(10);
        count_en = 0;
        check(tcount[3] == 5, "R5 ch3 follows ext clock 1", tcount[3], 5);
        check(tcount[0] == 3, "R5 ch0 follows ext clock 0", tcount[0], 3);
        check(tcount[4] == 0, "R5 R6 ch4 still silent", tcount[4], 0);
    endtask

    task automatic t_runt();
        write_cfg(1'b1, 20'h00000, 5'h03);   // ch0, ch1 code 0
        write_cfg(1'b0, 20'h00007, 5'h03);   // ps0 = 7
        wait_cyc(300);
        mon_en = 1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            while (tick[0] !== 1'b1) @(negedge clk);
            wait_cyc(i);
            write_cfg(1'b0, (i % 2 == 0) ? 20'h00002 : 20'h00007, 5'h03);
            write_cfg(1'b1, (i % 2 == 0) ? 20'h00030 : 20'h00000, 5'h02);
            wait_cyc(150);
        end
        mon_en = 0;
        check(mn[0] >= 6,   "R9 ch0 no runt interval", mn[0], 6);
        check(mx[0] <= 16,  "R9 ch0 no stretched interval", mx[0], 16);
        check(mn[1] >= 6,   "R9 ch1 no runt interval", mn[1], 6);
        check(mx[1] <= 128, "R9 ch1 no stretched interval", mx[1], 128);
    endtask

    initial begin
        t_reset();
        t_groups();
        t_isolation();
        t_off();
        t_ext();
        t_runt();
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        summary();
    end
endmodule